// File: doc/BRIEF.md
# Dual-Order Burst Address Counter

This block produces the word address used by a synchronous memory during a four-beat burst. A load command captures the whole external address. The two lowest bits of that address become the starting point of a 2-bit burst sequence. Each advance command after that moves to the next word of the burst. The upper address bits stay fixed for the whole burst, so the burst never leaves its aligned four-word block.

Two burst orders are available, and a static mode input picks one of them. In linear order, the low field counts upward and wraps modulo four. In interleaved order, the low field is the starting value XORed with a beat count of 0, 1, 2, 3. When the stall input is high, the clock edge is treated as if it had not happened. A load also needs the chip-select qualifier to be true. An advance ignores both the external address and the select. Advancing past the fourth beat keeps cycling through the same block until the next load.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_i` is high at a rising edge, the next value of `addr_o` is all zeros, and the beat count is cleared.
- R2: At an edge where `stall_i`=0, `sel_i`=1 and `adv_i`=0, `addr_o` takes the value of `addr_i` after that edge. The beat count restarts at 0.
- R3: At an edge where `stall_i`=0, `sel_i`=0 and `adv_i`=0, nothing is loaded, and `addr_o` keeps its value.
- R4: At an edge where `stall_i`=1, `addr_o` keeps its value, whatever the other inputs are.
- R5: With `ilv_mode_i`=0 (linear), each advance edge (`stall_i`=0, `adv_i`=1) sets `addr_o[1:0]` to the previous `addr_o[1:0]` plus 1, modulo 4.
- R6: With `ilv_mode_i`=1 (interleaved), after the k-th advance since the last load, `addr_o[1:0]` equals the loaded low field XOR (k mod 4). For example, start 2 gives the sequence 2, 3, 0, 1.
- R7: On an advance edge, `addr_i` and `sel_i` are ignored, and `addr_o[ADDR_W-1:2]` does not change.
- R8: Advances beyond the fourth beat keep wrapping within the same four-word block. The fourth advance returns `addr_o` to the loaded address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| stall_i | input | 1 | Freeze: when high, the edge has no effect |
| sel_i | input | 1 | Combined chip-select qualifier, high when selected |
| adv_i | input | 1 | 1 = advance the burst, 0 = load a new address |
| ilv_mode_i | input | 1 | Burst order: 1 = interleaved, 0 = linear |
| addr_i | input | ADDR_W | External word address |
| addr_o | output | ADDR_W | Current internal burst address |

## Verification
The assertions assume that `ilv_mode_i` is static. It may change only while `rst_i` is high. If it changed at any other time, the combinational order selection would alter `addr_o` during a stall, and the hold property would fail. The bench therefore sets the mode only inside a reset pulse, then sweeps every start value under several upper-address patterns in that mode. During stall, deselect and advance cycles, it drives `addr_i` with values that differ from the held address, so that any leakage of the input would be visible.

// File: rtl/burst_pkg.sv
package burst_pkg;

    // Width of the burst field: a four-beat burst needs two bits.
    localparam int unsigned BEAT_W = 2;

    typedef logic [BEAT_W-1:0] beat_t;

    // Decoded command seen at one clock edge.
    typedef enum logic [1:0] {
        CMD_HOLD = 2'd0,
        CMD_LOAD = 2'd1,
        CMD_STEP = 2'd2
    } cmd_e;

endpackage

// File: rtl/burst_cmd_decode.sv
module burst_cmd_decode
    import burst_pkg::*;
(
    input  logic stall_i,
    input  logic sel_i,
    input  logic adv_i,
    output cmd_e cmd_o
);

    // Priority: the freeze wins, then advance, then a qualified load.
    always_comb begin
        if (stall_i) begin
            cmd_o = CMD_HOLD;
        end else if (adv_i) begin
            cmd_o = CMD_STEP;
        end else if (sel_i) begin
            cmd_o = CMD_LOAD;
        end else begin
            cmd_o = CMD_HOLD;
        end
    end

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_pkg::*;
(
    input  beat_t base_i,
    input  beat_t beat_i,
    input  logic  ilv_i,
    output beat_t low_o
);

    beat_t lin_low;
    beat_t ilv_low;

    // Linear order: modulo-4 sum of the start value and the beat count.
    assign lin_low = beat_t'(base_i + beat_i);

    // Interleaved order: per-bit XOR of the start value and the beat count.
    for (genvar b = 0; b < BEAT_W; b++) begin : g_xor
        assign ilv_low[b] = base_i[b] ^ beat_i[b];
    end

    assign low_o = ilv_i ? ilv_low : lin_low;

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int unsigned ADDR_W = 18
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              stall_i,
    input  logic              sel_i,
    input  logic              adv_i,
    input  logic              ilv_mode_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] addr_o
);

    localparam int unsigned UP_W = ADDR_W - BEAT_W;

    typedef struct packed {
        logic [UP_W-1:0] upper;
        beat_t           base;
        beat_t           beat;
    } state_t;

    state_t st_d;
    state_t st_q;
    cmd_e   cmd;
    beat_t  low;

    burst_cmd_decode i_decode (
        .stall_i (stall_i),
        .sel_i   (sel_i),
        .adv_i   (adv_i),
        .cmd_o   (cmd)
    );

    burst_order_map i_order (
        .base_i (st_q.base),
        .beat_i (st_q.beat),
        .ilv_i  (ilv_mode_i),
        .low_o  (low)
    );

    // Next-state process.
    always_comb begin
        st_d = st_q;
        unique case (cmd)
            CMD_LOAD: begin
                st_d.upper = addr_i[ADDR_W-1:BEAT_W];
                st_d.base  = addr_i[BEAT_W-1:0];
                st_d.beat  = '0;
            end
            CMD_STEP: begin
                st_d.beat = beat_t'(st_q.beat + 1'b1);
            end
            default: begin
                st_d = st_q;
            end
        endcase
    end

    // Register process.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_o = {st_q.upper, low};

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk
    import burst_pkg::*;
#(
    parameter int unsigned ADDR_W = 18
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              stall_i,
    input logic              sel_i,
    input logic              adv_i,
    input logic              ilv_mode_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [ADDR_W-1:0] addr_o
);

    // Port-level model of the start value and the beat count since the last load.
    beat_t ref_base;
    beat_t ref_beat;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ref_base <= '0;
            ref_beat <= '0;
        end else if (!stall_i && adv_i) begin
            ref_beat <= beat_t'(ref_beat + 1'b1);
        end else if (!stall_i && sel_i) begin
            ref_base <= addr_i[BEAT_W-1:0];
            ref_beat <= '0;
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk_i)
        rst_i |=> addr_o == '0);

    assert_load_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (!stall_i && sel_i && !adv_i) |=> addr_o == $past(addr_i));

    assert_deselect_hold_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (!stall_i && !sel_i && !adv_i) |=> $stable(addr_o));

    assert_stall_hold_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        stall_i |=> $stable(addr_o));

    assert_linear_step_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (!stall_i && adv_i && !ilv_mode_i) |=>
            addr_o[BEAT_W-1:0] == beat_t'($past(addr_o[BEAT_W-1:0]) + 1'b1));

    assert_interleave_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        ilv_mode_i |-> addr_o[BEAT_W-1:0] == (ref_base ^ ref_beat));

    assert_upper_fixed_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (!stall_i && adv_i) |=>
            addr_o[ADDR_W-1:BEAT_W] == $past(addr_o[ADDR_W-1:BEAT_W]));

    assert_wrap_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        !ilv_mode_i |-> addr_o[BEAT_W-1:0] == beat_t'(ref_base + ref_beat));

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .stall_i    (stall_i),
    .sel_i      (sel_i),
    .adv_i      (adv_i),
    .ilv_mode_i (ilv_mode_i),
    .addr_i     (addr_i),
    .addr_o     (addr_o)
);

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;

    localparam int AW = 18;

    logic          clk = 1'b0;
    logic          rst_i = 1'b1;
    logic          stall_i = 1'b0;
    logic          sel_i = 1'b0;
    logic          adv_i = 1'b0;
    logic          ilv_mode_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [AW-1:0] addr_o;

    int checks = 0;
    int errors = 0;

    // Bench model state, derived from the requirements.
    logic [AW-3:0] m_up = '0;
    logic [1:0]    m_base = '0;
    int            m_beat = 0;

    always #2 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW)) i_burst_addr_gen (
        .clk_i      (clk),
        .rst_i      (rst_i),
        .stall_i    (stall_i),
        .sel_i      (sel_i),
        .adv_i      (adv_i),
        .ilv_mode_i (ilv_mode_i),
        .addr_i     (addr_i),
        .addr_o     (addr_o)
    );

    function automatic logic [AW-1:0] expected();
        logic [1:0] k;
        logic [1:0] lo;
        k  = 2'(m_beat % 4);
        lo = ilv_mode_i ? (m_base ^ k) : 2'((int'(m_base) + m_beat) % 4);
        return {m_up, lo};
    endfunction

    task automatic chk(input string tag, input logic [AW-1:0] exp);
        checks++;
        if (addr_o !== exp) begin
            errors++;
            $display("FAIL %s: addr_o=%h expected %h", tag, addr_o, exp);
        end
    endtask

    task automatic cyc(input logic st, input logic se, input logic ad, input logic [AW-1:0] a);
        stall_i = st;
        sel_i   = se;
        adv_i   = ad;
        addr_i  = a;
        @(posedge clk);
        #1;
        if (!st) begin
            if (ad) begin
                m_beat++;
            end else if (se) begin
                m_up   = a[AW-1:2];
                m_base = a[1:0];
                m_beat = 0;
            end
        end
    endtask

    task automatic do_reset(input logic mode);
        rst_i      = 1'b1;
        ilv_mode_i = mode;
        stall_i    = 1'b0;
        sel_i      = 1'b1;
        adv_i      = 1'b0;
        addr_i     = '1;
        @(posedge clk);
        @(posedge clk);
        #1;
        rst_i  = 1'b0;
        m_up   = '0;
        m_base = '0;
        m_beat = 0;
    endtask

    initial begin
        #(4 * 100000);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [AW-3:0] ups [3];
        logic [AW-1:0] held;
        ups[0] = '0;
        ups[1] = '1;
        ups[2] = 16'hA5C3;

        do_reset(1'b0);
        chk("R1 reset clears address", '0);

        for (int m = 0; m < 2; m++) begin
            do_reset(m[0]);
            chk("R1 reset clears address", '0);
            for (int u = 0; u < 3; u++) begin
                for (int s = 0; s < 4; s++) begin
                    logic [AW-1:0] a;
                    a = {ups[u], 2'(s)};
                    cyc(1'b0, 1'b1, 1'b0, a);
                    chk("R2 load", a);
                    for (int k = 1; k <= 6; k++) begin
                        cyc(1'b0, k[0], 1'b1, ~a);
                        if (k >= 4) begin
                            chk("R8 wrap within block", expected());
                        end else if (m == 1) begin
                            chk("R6 interleaved order, R7 input ignored", expected());
                        end else begin
                            chk("R5 linear order, R7 input ignored", expected());
                        end
                        if (k == 4) begin
                            chk("R8 fourth advance returns to start", a);
                        end
                    end
                    held = addr_o;
                    cyc(1'b1, 1'b1, 1'b0, ~a);
                    chk("R4 stall blocks load", held);
                    cyc(1'b1, 1'b1, 1'b1, ~a);
                    chk("R4 stall blocks advance", held);
                    cyc(1'b0, 1'b0, 1'b0, ~a);
                    chk("R3 deselected load ignored", held);
                    cyc(1'b0, 1'b0, 1'b1, ~a);
                    chk("R7 advance while deselected", expected());
                end
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule